// File: doc/BRIEF.md
# Sixteen-Bit Multicycle Processor Core

This block is a small load/store processor. It reads 16-bit instruction words from a 256-word unified memory, decodes them, and executes them one at a time. Each instruction passes through a fixed sequence of fetch, decode, execute and writeback states, with one extra memory state for instructions that touch memory. The core has eight 16-bit general registers, a 16-bit program counter and a three-bit condition register holding negative, zero and carry.

The core connects to one synchronous memory port. The memory returns read data one clock after the address is presented, and it commits a write on the clock edge where the write enable is high. A halt instruction stops the core, and the core then drives its `halted` output until the next reset. All opcodes share the top three bits `111`. Any other word executes as a no-operation.

Top module: `mcpu16_core`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `halted` is 0, `mem_we` is 0 and `mem_addr` is 0. Reset sets the program counter, the condition bits and the general registers to zero.
- R2: An instruction word is {opcode[15:9], dst[8:6], srcA[5:3], srcB[2:0]}. `add` (1110000) writes srcA+srcB to dst. `sub` (1110001) writes srcA−srcB to dst.
- R3: `cmp` (1110010) updates the condition bits as `sub` does and writes no register. `je` (1111100) is taken when Z=1. A taken conditional jump sets the program counter to its own address plus bits 7..0, sign-extended. A jump that is not taken advances the program counter by 1.
- R4: `inc` (1110110) and `dec` (1110111) write srcB±1 to dst. `jne` (1111101) is taken when Z=0, and a negative offset jumps backwards.
- R5: `mov` (1110011) copies srcB. `shl` (1110100) and `shr` (1110101) shift srcB left or right (logical) by one bit, and C takes the bit shifted out. `add` and `inc` set C to the carry out. `jc` (1111110) is taken when C=1.
- R6: `load` (1111000) reads memory at the address held in srcB into dst. `store` (1111001) writes srcA to the address held in srcB. Only the low 8 bits of an address are used.
- R7: `loadi` (1111010) writes the word that follows it in memory to dst, and it advances the program counter by 2.
- R8: `jmp` (1111111) sets the program counter to the contents of the register in bits 5..3.
- R9: A word whose bits 15..13 are not 111 changes no register or memory word and advances the program counter by 1.
- R10: `halt` (1111011) raises `halted` and holds it until reset. While halted, `mem_addr` stays at the address of the halt word and `mem_we` stays 0.
- R11: A non-memory instruction takes 4 cycles. `load`, `store` and `loadi` take 5 cycles. `halted` rises 3 cycles after a halt word is fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| mem_we | output | 1 | Memory write enable |
| halted | output | 1 | Core has executed halt |

## Verification
The hardest things to observe are the register file and the condition bits, because neither reaches a port. Each scenario is therefore a short program. The program routes its results through conditional jumps that skip marker writes, and then stores the registers to known addresses in the bench memory. A counted backward loop checks negative offsets and the exact cycle total together. An all-ones increment drives the carry bit that `jc` depends on. A store whose address register has bits set above bit 7 checks the address truncation.

// File: rtl/mcpu16_pkg.sv
package mcpu16_pkg;

    localparam int OPC_W = 7;

    localparam logic [6:0] OPC_ADD   = 7'b1110000;
    localparam logic [6:0] OPC_SUB   = 7'b1110001;
    localparam logic [6:0] OPC_CMP   = 7'b1110010;
    localparam logic [6:0] OPC_MOV   = 7'b1110011;
    localparam logic [6:0] OPC_SHL   = 7'b1110100;
    localparam logic [6:0] OPC_SHR   = 7'b1110101;
    localparam logic [6:0] OPC_INC   = 7'b1110110;
    localparam logic [6:0] OPC_DEC   = 7'b1110111;
    localparam logic [6:0] OPC_LOAD  = 7'b1111000;
    localparam logic [6:0] OPC_STORE = 7'b1111001;
    localparam logic [6:0] OPC_LOADI = 7'b1111010;
    localparam logic [6:0] OPC_HALT  = 7'b1111011;
    localparam logic [6:0] OPC_JE    = 7'b1111100;
    localparam logic [6:0] OPC_JNE   = 7'b1111101;
    localparam logic [6:0] OPC_JC    = 7'b1111110;
    localparam logic [6:0] OPC_JMP   = 7'b1111111;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB, ST_HALT
    } state_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_MOV, ALU_SHL, ALU_SHR, ALU_INC, ALU_DEC
    } alu_op_e;

    typedef enum logic [1:0] {
        CND_EQ, CND_NE, CND_CS
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
    } flags_t;

    typedef struct packed {
        logic    use_alu;
        alu_op_e aop;
        logic    wr_reg;
        logic    ld;
        logic    st;
        logic    ldi;
        logic    hlt;
        logic    cjmp;
        cond_e   cond;
        logic    rjmp;
    } decode_t;

endpackage

// File: rtl/mcpu16_decode.sv
module mcpu16_decode
    import mcpu16_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output decode_t          dec
);
    always_comb begin
        dec = '0;
        dec.aop  = ALU_ADD;
        dec.cond = CND_EQ;
        case (opcode)
            OPC_ADD:   begin dec.use_alu = 1'b1; dec.aop = ALU_ADD; dec.wr_reg = 1'b1; end
            OPC_SUB:   begin dec.use_alu = 1'b1; dec.aop = ALU_SUB; dec.wr_reg = 1'b1; end
            OPC_CMP:   begin dec.use_alu = 1'b1; dec.aop = ALU_SUB; end
            OPC_MOV:   begin dec.use_alu = 1'b1; dec.aop = ALU_MOV; dec.wr_reg = 1'b1; end
            OPC_SHL:   begin dec.use_alu = 1'b1; dec.aop = ALU_SHL; dec.wr_reg = 1'b1; end
            OPC_SHR:   begin dec.use_alu = 1'b1; dec.aop = ALU_SHR; dec.wr_reg = 1'b1; end
            OPC_INC:   begin dec.use_alu = 1'b1; dec.aop = ALU_INC; dec.wr_reg = 1'b1; end
            OPC_DEC:   begin dec.use_alu = 1'b1; dec.aop = ALU_DEC; dec.wr_reg = 1'b1; end
            OPC_LOAD:  begin dec.ld  = 1'b1; dec.wr_reg = 1'b1; end
            OPC_STORE: begin dec.st  = 1'b1; end
            OPC_LOADI: begin dec.ldi = 1'b1; dec.wr_reg = 1'b1; end
            OPC_HALT:  begin dec.hlt = 1'b1; end
            OPC_JE:    begin dec.cjmp = 1'b1; dec.cond = CND_EQ; end
            OPC_JNE:   begin dec.cjmp = 1'b1; dec.cond = CND_NE; end
            OPC_JC:    begin dec.cjmp = 1'b1; dec.cond = CND_CS; end
            OPC_JMP:   begin dec.rjmp = 1'b1; end
            default:   ;
        endcase
    end
endmodule

// File: rtl/mcpu16_alu.sv
module mcpu16_alu
    import mcpu16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         c_in,
    output logic [W-1:0] res,
    output flags_t       fl
);
    logic [W:0] wide;

    always_comb begin
        wide = '0;
        case (op)
            ALU_ADD: wide = {1'b0, a} + {1'b0, b};
            ALU_SUB: wide = {1'b0, a} - {1'b0, b};
            ALU_MOV: wide = {c_in, b};
            ALU_SHL: wide = {b, 1'b0};
            ALU_SHR: wide = {b[0], 1'b0, b[W-1:1]};
            ALU_INC: wide = {1'b0, b} + {{W{1'b0}}, 1'b1};
            ALU_DEC: wide = {1'b0, b} - {{W{1'b0}}, 1'b1};
            default: wide = {c_in, b};
        endcase
        res  = wide[W-1:0];
        fl.c = wide[W];
        fl.n = wide[W-1];
        fl.z = (wide[W-1:0] == '0);
    end
endmodule

// File: rtl/mcpu16_regfile.sv
module mcpu16_regfile #(
    parameter int W      = 16,
    parameter int NREGS  = 8,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [W-1:0]     wdata,
    input  logic [IDX_W-1:0] raddr_a,
    input  logic [IDX_W-1:0] raddr_b,
    output logic [W-1:0]     rdata_a,
    output logic [W-1:0]     rdata_b
);
    logic [W-1:0] regs_q [NREGS];
    logic [W-1:0] regs_d [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we) begin
            regs_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            if (rst) regs_q[i] <= '0;
            else     regs_q[i] <= regs_d[i];
        end
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];
endmodule

// File: rtl/mcpu16_core.sv
module mcpu16_core
    import mcpu16_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int MEM_AW  = 8,
    parameter int NUM_REG = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic              halted
);
    localparam int IDX_W = $clog2(NUM_REG);
    localparam int OFS_W = 8;

    typedef struct packed {
        state_e            st;
        logic [DATA_W-1:0] pc;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] res;
        flags_t            fl;
    } core_t;

    core_t   q, d;
    decode_t dec;

    logic [DATA_W-1:0] ra, rb, alu_res;
    flags_t            alu_fl;
    logic              rf_we;
    logic              taken;
    logic [DATA_W-1:0] ofs_ext;

    mcpu16_decode u_dec (
        .opcode (q.ir[DATA_W-1 -: OPC_W]),
        .dec    (dec)
    );

    mcpu16_regfile #(.W(DATA_W), .NREGS(NUM_REG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .waddr   (q.ir[8:6]),
        .wdata   (q.res),
        .raddr_a (q.ir[5:3]),
        .raddr_b (q.ir[2:0]),
        .rdata_a (ra),
        .rdata_b (rb)
    );

    mcpu16_alu #(.W(DATA_W)) u_alu (
        .op   (dec.aop),
        .a    (ra),
        .b    (rb),
        .c_in (q.fl.c),
        .res  (alu_res),
        .fl   (alu_fl)
    );

    assign ofs_ext = {{(DATA_W-OFS_W){q.ir[OFS_W-1]}}, q.ir[OFS_W-1:0]};

    always_comb begin
        case (dec.cond)
            CND_EQ:  taken = q.fl.z;
            CND_NE:  taken = !q.fl.z;
            CND_CS:  taken = q.fl.c;
            default: taken = 1'b0;
        endcase
    end

    always_comb begin
        d         = q;
        mem_addr  = q.pc[MEM_AW-1:0];
        mem_wdata = ra;
        mem_we    = 1'b0;
        rf_we     = 1'b0;
        case (q.st)
            ST_FETCH: d.st = ST_DECODE;
            ST_DECODE: begin
                d.ir = mem_rdata;
                d.st = ST_EXEC;
            end
            ST_EXEC: begin
                if (dec.hlt) begin
                    d.st = ST_HALT;
                end else if (dec.ld) begin
                    mem_addr = rb[MEM_AW-1:0];
                    d.st     = ST_MEM;
                end else if (dec.ldi) begin
                    mem_addr = q.pc[MEM_AW-1:0] + 1'b1;
                    d.st     = ST_MEM;
                end else if (dec.st) begin
                    mem_addr = rb[MEM_AW-1:0];
                    mem_we   = 1'b1;
                    d.st     = ST_MEM;
                end else begin
                    if (dec.use_alu) begin
                        d.res = alu_res;
                        d.fl  = alu_fl;
                    end
                    d.st = ST_WB;
                end
            end
            ST_MEM: begin
                d.res = mem_rdata;
                d.st  = ST_WB;
            end
            ST_WB: begin
                rf_we = dec.wr_reg;
                if (dec.ldi)                 d.pc = q.pc + 2'd2;
                else if (dec.cjmp && taken)  d.pc = q.pc + ofs_ext;
                else if (dec.rjmp)           d.pc = ra;
                else                         d.pc = q.pc + 1'b1;
                d.st = ST_FETCH;
            end
            default: d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st  <= ST_FETCH;
            q.pc  <= '0;
            q.ir  <= '0;
            q.res <= '0;
            q.fl  <= '0;
        end else begin
            q <= d;
        end
    end

    assign halted = (q.st == ST_HALT);

    assert_fetch_to_decode_R11: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_FETCH) |=> (q.st == ST_DECODE));

    assert_mem_to_wb_R11: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_MEM) |=> (q.st == ST_WB));

    assert_write_then_mem_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (q.st == ST_MEM && !mem_we));

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    assert_halt_addr_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(mem_addr));

    assert_halt_no_write_R10: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we);
endmodule

// File: tb/tb_mcpu16_core.sv
module tb_mcpu16_core;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_LIMIT  = 3000;

    localparam logic [6:0] ADD = 7'b1110000, SUB = 7'b1110001, CMP = 7'b1110010;
    localparam logic [6:0] MOV = 7'b1110011, SHL = 7'b1110100, SHR = 7'b1110101;
    localparam logic [6:0] INC = 7'b1110110, DEC = 7'b1110111, LOAD = 7'b1111000;
    localparam logic [6:0] STORE = 7'b1111001, LOADI = 7'b1111010, HALT = 7'b1111011;
    localparam logic [6:0] JE = 7'b1111100, JNE = 7'b1111101, JC = 7'b1111110, JMP = 7'b1111111;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_we;
    logic        halted;
    logic [15:0] ram [256];

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
    end

    mcpu16_core dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .halted(halted)
    );

    function automatic logic [15:0] enc(input logic [6:0] op, input int dd, input int sa, input int sb);
        enc = {op, dd[2:0], sa[2:0], sb[2:0]};
    endfunction

    function automatic logic [15:0] encj(input logic [6:0] op, input int ofs);
        encj = {op, 1'b0, ofs[7:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) ram[i] = 16'h0000;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 halted in reset", halted, 0);
        check("R1 we in reset", mem_we, 0);
        check("R1 addr in reset", mem_addr, 0);
        rst = 1'b0;
    endtask

    task automatic run(output int cycles);
        cycles = 0;
        while (!halted && cycles < RUN_LIMIT) begin
            @(posedge clk);
            #1;
            cycles++;
        end
        if (!halted) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual not halted expected halted");
        end
    endtask

    task automatic t_reset();
        int cyc;
        clear_mem();
        ram[0] = enc(HALT, 0, 0, 0);
        do_reset();
        check("R1 addr first cycle", mem_addr, 0);
        check("R1 halted first cycle", halted, 0);
        run(cyc);
        check("R11 halt latency", cyc, 3);
        do_reset();
        check("R1 halt cleared by reset", halted, 0);
    endtask

    task automatic t_arith();
        int cyc;
        clear_mem();
        ram[0] = enc(LOADI, 1, 0, 0); ram[1] = 16'd100;
        ram[2] = enc(LOADI, 2, 0, 0); ram[3] = 16'd23;
        ram[4] = enc(LOADI, 5, 0, 0); ram[5] = 16'h0080;
        ram[6] = enc(ADD, 3, 1, 2);
        ram[7] = enc(SUB, 4, 1, 2);
        ram[8] = enc(STORE, 0, 3, 5);
        ram[9] = enc(INC, 5, 0, 5);
        ram[10] = enc(STORE, 0, 4, 5);
        ram[11] = enc(SUB, 6, 2, 1);
        ram[12] = enc(INC, 5, 0, 5);
        ram[13] = enc(STORE, 0, 6, 5);
        ram[14] = enc(HALT, 0, 0, 0);
        do_reset();
        run(cyc);
        check("R2 add", ram[8'h80], 123);
        check("R2 sub", ram[8'h81], 77);
        check("R2 sub negative", ram[8'h82], 16'hFFB3);
        check("R7 loadi", ram[1], 100);
    endtask

    task automatic t_cmp_je();
        int cyc;
        clear_mem();
        ram[0] = enc(LOADI, 1, 0, 0); ram[1] = 16'd5;
        ram[2] = enc(LOADI, 2, 0, 0); ram[3] = 16'd5;
        ram[4] = enc(LOADI, 7, 0, 0); ram[5] = 16'h0090;
        ram[6] = enc(CMP, 0, 1, 2);
        ram[7] = encj(JE, 3);
        ram[8] = enc(LOADI, 3, 0, 0); ram[9] = 16'h0BAD;
        ram[10] = enc(LOADI, 3, 0, 0); ram[11] = 16'h600D;
        ram[12] = enc(STORE, 0, 3, 7);
        ram[13] = enc(INC, 7, 0, 7);
        ram[14] = enc(STORE, 0, 0, 7);
        ram[15] = enc(CMP, 0, 1, 7);
        ram[16] = encj(JE, 3);
        ram[17] = enc(INC, 7, 0, 7);
        ram[18] = enc(STORE, 0, 1, 7);
        ram[19] = enc(HALT, 0, 0, 0);
        do_reset();
        run(cyc);
        check("R3 je taken skips marker", ram[8'h90], 16'h600D);
        check("R3 cmp writes no register", ram[8'h91], 0);
        check("R3 je not taken falls through", ram[8'h92], 5);
    endtask

    task automatic t_loop();
        int cyc;
        clear_mem();
        ram[0] = enc(LOADI, 1, 0, 0); ram[1] = 16'd3;
        ram[2] = enc(LOADI, 2, 0, 0); ram[3] = 16'd0;
        ram[4] = enc(LOADI, 7, 0, 0); ram[5] = 16'h00A0;
        ram[6] = enc(INC, 2, 0, 2);
        ram[7] = enc(DEC, 1, 0, 1);
        ram[8] = encj(JNE, -2);
        ram[9] = enc(STORE, 0, 2, 7);
        ram[10] = enc(HALT, 0, 0, 0);
        do_reset();
        run(cyc);
        check("R4 backward jne loop count", ram[8'hA0], 3);
        check("R11 cycle total", cyc, 59);
    endtask

    task automatic t_carry_shift();
        int cyc;
        clear_mem();
        ram[0] = enc(LOADI, 1, 0, 0); ram[1] = 16'hFFFF;
        ram[2] = enc(LOADI, 7, 0, 0); ram[3] = 16'h00B0;
        ram[4] = enc(INC, 2, 0, 1);
        ram[5] = encj(JC, 3);
        ram[6] = enc(LOADI, 2, 0, 0); ram[7] = 16'h1111;
        ram[8] = enc(STORE, 0, 2, 7);
        ram[9] = enc(LOADI, 3, 0, 0); ram[10] = 16'h8001;
        ram[11] = enc(SHL, 4, 0, 3);
        ram[12] = enc(SHR, 5, 0, 3);
        ram[13] = enc(INC, 7, 0, 7);
        ram[14] = enc(STORE, 0, 4, 7);
        ram[15] = enc(INC, 7, 0, 7);
        ram[16] = enc(STORE, 0, 5, 7);
        ram[17] = enc(MOV, 6, 0, 3);
        ram[18] = enc(DEC, 6, 0, 6);
        ram[19] = enc(INC, 7, 0, 7);
        ram[20] = enc(STORE, 0, 6, 7);
        ram[21] = enc(SHL, 4, 0, 4);
        ram[22] = encj(JC, 3);
        ram[23] = enc(INC, 7, 0, 7);
        ram[24] = enc(STORE, 0, 4, 7);
        ram[25] = enc(HALT, 0, 0, 0);
        do_reset();
        run(cyc);
        check("R5 inc carry then jc taken", ram[8'hB0], 0);
        check("R5 shl", ram[8'hB1], 16'h0002);
        check("R5 shr logical", ram[8'hB2], 16'h4000);
        check("R5 mov then R4 dec", ram[8'hB3], 16'h8000);
        check("R5 jc not taken when carry clear", ram[8'hB4], 16'h0004);
    endtask

    task automatic t_load_jmp();
        int cyc;
        clear_mem();
        ram[8'hC0] = 16'h1234;
        ram[0] = enc(LOADI, 5, 0, 0); ram[1] = 16'h00C0;
        ram[2] = enc(LOAD, 1, 0, 5);
        ram[3] = enc(LOADI, 6, 0, 0); ram[4] = 16'd9;
        ram[5] = enc(JMP, 0, 6, 0);
        ram[6] = enc(LOADI, 1, 0, 0); ram[7] = 16'hDEAD;
        ram[8] = enc(HALT, 0, 0, 0);
        ram[9] = enc(INC, 5, 0, 5);
        ram[10] = enc(STORE, 0, 1, 5);
        ram[11] = enc(HALT, 0, 0, 0);
        do_reset();
        run(cyc);
        check("R6 load via srcB address", ram[8'hC1], 16'h1234);
        check("R8 jmp to register target", mem_addr, 11);
    endtask

    task automatic t_undef_halt();
        int cyc;
        int bad_we;
        clear_mem();
        ram[0] = 16'h5A5A;
        ram[1] = enc(LOADI, 1, 0, 0); ram[2] = 16'h0077;
        ram[3] = enc(LOADI, 2, 0, 0); ram[4] = 16'h01D0;
        ram[5] = enc(STORE, 0, 1, 2);
        ram[6] = enc(HALT, 0, 0, 0);
        do_reset();
        run(cyc);
        check("R9 undefined word is nop", ram[0], 16'h5A5A);
        check("R6 address truncated to 8 bits", ram[8'hD0], 16'h0077);
        check("R11 mixed cycle total", cyc, 22);
        bad_we = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (mem_we) bad_we++;
        end
        check("R10 still halted", halted, 1);
        check("R10 addr frozen at halt word", mem_addr, 6);
        check("R10 no writes while halted", bad_we, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        clear_mem();
        t_reset();
        t_arith();
        t_cmp_je();
        t_loop();
        t_carry_shift();
        t_load_jmp();
        t_undef_halt();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule